// File: doc/BRIEF.md
# Serial Slave Pause and Low-Power Controller

This block sits beside the command engine of a serial memory slave and handles the two ways its normal traffic can be interrupted. The first is a pause. While the slave is selected, the master pulls the pause line low to freeze the command in progress without deselecting the slave. The controller records the serial clock level at the moment the pause begins. It lets the command resume only when the pause line returns high while the serial clock is back at that same level. Deselecting the slave during a pause kills the command, and the controller reports that with a one-cycle abort pulse.

The second is a low-power doze. The engine raises a strobe when it has decoded the doze op-code, and this arms the controller. The doze starts on the following deselect, unless a serial clock rising edge comes first, in which case the request is cancelled. A later select falling edge starts a wake-up countdown measured in system clock cycles. When the countdown ends, the controller emits a one-cycle wake pulse, which the protection logic uses to clear its write-enable state, and commands are accepted again. A second select falling edge during the countdown is illegal. It sets a sticky error flag and leaves the countdown untouched.

All select, serial clock and pause inputs are assumed to be already synchronised to `clk`.

Top module: `ps_ctrl`

## Requirements
- R1: After reset, `freeze`, `so_hiz`, `dozing`, `wake_pulse`, `pause_abort` and `wake_err` are 0 and `cmd_ready` is 1.
- R2: A pause starts only while `sel_n` is 0 and the slave is not dozing. When `pause_n` is sampled low, `freeze` is 1 from the next cycle. `so_hiz` is 1 during a pause only when `rd_active` is 1. With `sel_n` at 1, `pause_n` has no effect.
- R3: A pause ends, with `freeze` returning to 0 one cycle later, only on a cycle in which `pause_n` is 1 and `sclk` equals the level `sclk` had when the pause began. `pause_n` returning high at the other `sclk` level keeps the pause active.
- R4: If `sel_n` is sampled 1 while a pause is active, the pause ends and `pause_abort` is 1 for exactly the next cycle.
- R5: A `doze_cmd` strobe sampled while `sel_n` is 0 arms the doze. The next rising edge of `sel_n` then sets `dozing` and clears `cmd_ready` in the following cycle.
- R6: A rising edge of `sclk` seen while armed cancels the doze, and the later `sel_n` rise leaves `dozing` at 0. A falling edge of `sclk` while armed does not cancel.
- R7: While `dozing` is 1, `freeze` and `so_hiz` are 1 and `cmd_ready` is 0, and toggling `sclk` changes none of them.
- R8: A falling edge of `sel_n` while dozing starts a countdown of `RECOV_CYCLES` clocks, during which `sel_n` may return high. Exactly `RECOV_CYCLES` cycles after the edge, `dozing` falls, `cmd_ready` rises and `wake_pulse` is 1 for one cycle.
- R9: A second falling edge of `sel_n` during the countdown sets `wake_err`, which stays 1 until reset. The countdown is not restarted, so the wake-up time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Synchronised active-low slave select |
| sclk | input | 1 | Synchronised serial clock level |
| pause_n | input | 1 | Synchronised active-low pause request |
| doze_cmd | input | 1 | One-cycle strobe: doze op-code decoded |
| rd_active | input | 1 | Engine is currently driving read data out |
| freeze | output | 1 | Engine must hold its state and ignore serial input |
| so_hiz | output | 1 | Forces the serial data output to high impedance |
| dozing | output | 1 | Doze or wake-up countdown in progress |
| cmd_ready | output | 1 | New commands may be accepted |
| wake_pulse | output | 1 | One-cycle pulse when wake-up completes |
| pause_abort | output | 1 | One-cycle pulse: deselect during a pause |
| wake_err | output | 1 | Sticky: select fell again during wake-up |

## Verification
Some properties are checked on every cycle by the embedded assertions. These are: a pause begins only while selected with the pause line low; a pause ends only on a deselect or at the recorded clock level; an abort is always preceded by a pause and a deselect; the doze starts only on a deselected cycle; the wake pulse lasts one cycle; and the error flag is sticky. Other behaviour can only be shown by the bench scenarios. These cover the exact length of the wake-up countdown, cancellation by a clock rising edge compared with no cancellation on a falling edge, the pause exit waiting at the wrong clock level, and the countdown ignoring an illegal second select edge.

// File: rtl/ps_pkg.sv
package ps_pkg;

  // Low-power sequencing states
  typedef enum logic [1:0] {
    DZ_IDLE  = 2'd0,
    DZ_ARMED = 2'd1,
    DZ_SLEEP = 2'd2,
    DZ_RECOV = 2'd3
  } doze_st_t;

  // Edge events derived from the synchronised pins
  typedef struct packed {
    logic sel_fall;
    logic sel_rise;
    logic sclk_rise;
  } pin_evt_t;

endpackage

// File: rtl/ps_edges.sv
module ps_edges
  import ps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n,
  input  logic     sclk,
  output pin_evt_t evt
);

  logic sel_q, sclk_q;
  logic sel_d, sclk_d;

  always_comb begin
    sel_d  = sel_n;
    sclk_d = sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      sclk_q <= sclk_d;
    end
  end

  always_comb begin
    evt.sel_fall  = sel_q & ~sel_n;
    evt.sel_rise  = ~sel_q & sel_n;
    evt.sclk_rise = ~sclk_q & sclk;
  end

endmodule

// File: rtl/ps_pause.sv
module ps_pause (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic pause_n,
  input  logic block,
  output logic active,
  output logic abort
);

  logic act_q, act_d;
  logic lvl_q, lvl_d;
  logic abort_q, abort_d;
  logic lvl_en;

  // Next-state: enter on a low pause line while selected; record the clock
  // level; leave only at that level or on deselect.
  always_comb begin
    act_d   = act_q;
    lvl_d   = lvl_q;
    lvl_en  = 1'b0;
    abort_d = 1'b0;
    if (sel_n) begin
      act_d   = 1'b0;
      abort_d = act_q;
    end else if (!act_q) begin
      if (!pause_n && !block) begin
        act_d  = 1'b1;
        lvl_en = 1'b1;
        lvl_d  = sclk;
      end
    end else if (pause_n && (sclk == lvl_q)) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      act_q   <= act_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (lvl_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign active = act_q;
  assign abort  = abort_q;

  // R2: a pause only starts from a selected cycle with the pause line low
  p_pause_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(!sel_n && !pause_n && !block));

  // R3: a pause ends only on deselect or at the recorded clock level
  p_pause_exit_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(sel_n) || ($past(pause_n) && ($past(sclk) == lvl_q))));

  // R4: abort follows an active pause that saw a deselect
  p_abort_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> ($past(act_q) && $past(sel_n)));

  p_abort_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);

endmodule

// File: rtl/ps_doze.sv
module ps_doze
  import ps_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 20000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_n,
  input  logic     doze_cmd,
  input  pin_evt_t evt,
  output logic     dozing,
  output logic     wake,
  output logic     err
);

  localparam int unsigned RC = (RECOV_CYCLES < 1) ? 1 : RECOV_CYCLES;
  localparam int unsigned CW = $clog2(RC + 1);

  doze_st_t      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          wake_q, wake_d;
  logic          err_q, err_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    wake_d = 1'b0;
    err_d  = err_q;
    unique case (st_q)
      DZ_IDLE: begin
        if (doze_cmd && !sel_n) st_d = DZ_ARMED;
      end
      DZ_ARMED: begin
        if (evt.sclk_rise)     st_d = DZ_IDLE;
        else if (evt.sel_rise) st_d = DZ_SLEEP;
      end
      DZ_SLEEP: begin
        if (evt.sel_fall) begin
          st_d   = DZ_RECOV;
          cnt_en = 1'b1;
          cnt_d  = CW'(RC);
        end
      end
      DZ_RECOV: begin
        if (evt.sel_fall) err_d = 1'b1;
        if (cnt_q == CW'(1)) begin
          st_d   = DZ_IDLE;
          wake_d = 1'b1;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - CW'(1);
        end
      end
      default: st_d = DZ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DZ_IDLE;
      wake_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign dozing = (st_q == DZ_SLEEP) || (st_q == DZ_RECOV);
  assign wake   = wake_q;
  assign err    = err_q;

  // R5: the doze begins only on a cycle that sampled the slave deselected
  p_doze_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dozing) |-> $past(sel_n));

  // R8: the wake pulse ends dozing and lasts one cycle
  p_wake_after_doze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> ($past(dozing) && !dozing));

  p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  // R9: the countdown error flag never clears
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R8: the countdown never leaves its loaded range
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DZ_RECOV) |-> ((cnt_q != '0) && (cnt_q <= CW'(RC))));

endmodule

// File: rtl/ps_ctrl.sv
module ps_ctrl
  import ps_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic pause_n,
  input  logic doze_cmd,
  input  logic rd_active,
  output logic freeze,
  output logic so_hiz,
  output logic dozing,
  output logic cmd_ready,
  output logic wake_pulse,
  output logic pause_abort,
  output logic wake_err
);

  pin_evt_t evt;
  logic     pause_act;
  logic     doze_flag;

  ps_edges u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (sel_n),
    .sclk  (sclk),
    .evt   (evt)
  );

  ps_pause u_pause (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .sclk    (sclk),
    .pause_n (pause_n),
    .block   (doze_flag),
    .active  (pause_act),
    .abort   (pause_abort)
  );

  ps_doze #(.RECOV_CYCLES(RECOV_CYCLES)) u_doze (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .doze_cmd (doze_cmd),
    .evt      (evt),
    .dozing   (doze_flag),
    .wake     (wake_pulse),
    .err      (wake_err)
  );

  always_comb begin
    freeze    = pause_act | doze_flag;
    so_hiz    = doze_flag | (pause_act & rd_active);
    dozing    = doze_flag;
    cmd_ready = ~doze_flag;
  end

  // R7: while dozing, the engine is frozen and the output released
  p_doze_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    doze_flag |-> (freeze && so_hiz && !cmd_ready));

  // R2: a pause and a doze never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_act && doze_flag));

endmodule

// File: tb/tb_ps_ctrl.sv
module tb_ps_ctrl;

  localparam int REC = 20;

  logic clk, rst_n;
  logic sel_n, sclk, pause_n, doze_cmd, rd_active;
  logic freeze, so_hiz, dozing, cmd_ready, wake_pulse, pause_abort, wake_err;

  ps_ctrl #(.RECOV_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .pause_n(pause_n),
    .doze_cmd(doze_cmd), .rd_active(rd_active), .freeze(freeze),
    .so_hiz(so_hiz), .dozing(dozing), .cmd_ready(cmd_ready),
    .wake_pulse(wake_pulse), .pause_abort(pause_abort), .wake_err(wake_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    string      req;
    logic [6:0] val;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // vector order: freeze, so_hiz, dozing, cmd_ready, wake_err, wake_pulse, pause_abort
  function automatic logic [6:0] v(bit f, bit h, bit d, bit r, bit e, bit w, bit a);
    return {f, h, d, r, e, w, a};
  endfunction

  task automatic exp_at(int due, string req, logic [6:0] val);
    exp_t it;
    it.due = due; it.req = req; it.val = val;
    q.push_back(it);
  endtask

  task automatic exp_next(string req, logic [6:0] val);
    exp_at(cyc + 1, req, val);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare due items against the outputs
  always @(negedge clk) begin
    logic [6:0] act;
    act = {freeze, so_hiz, dozing, cmd_ready, wake_err, wake_pulse, pause_abort};
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.due != cyc || act !== it.val) begin
        errors++;
        $display("FAIL %s cycle %0d actual %b expected %b", it.req, cyc, act, it.val);
      end
    end
  end

  initial begin
    int lim;
    lim = 5000;
    while (!done && cyc < lim) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; pause_n = 1'b1;
    doze_cmd = 1'b0; rd_active = 1'b0;
    tick(3);
    rst_n = 1'b1;
    exp_next("R1", v(0,0,0,1,0,0,0));
    tick(1);

    // R2/R3: pause entered with sclk low, read active
    sel_n = 1'b0; rd_active = 1'b1; tick(1);
    pause_n = 1'b0;
    exp_next("R2", v(1,1,0,1,0,0,0)); tick(1);
    sclk = 1'b1;
    exp_next("R2", v(1,1,0,1,0,0,0)); tick(1);
    pause_n = 1'b1;
    exp_next("R3", v(1,1,0,1,0,0,0)); tick(1);
    sclk = 1'b0;
    exp_next("R3", v(0,0,0,1,0,0,0)); tick(1);

    // R2/R3: pause entered with sclk high, no read
    rd_active = 1'b0; sclk = 1'b1; tick(1);
    pause_n = 1'b0;
    exp_next("R2", v(1,0,0,1,0,0,0)); tick(1);
    sclk = 1'b0; pause_n = 1'b1;
    exp_next("R3", v(1,0,0,1,0,0,0)); tick(1);
    sclk = 1'b1;
    exp_next("R3", v(0,0,0,1,0,0,0)); tick(1);

    // R4: deselect during pause
    sclk = 1'b0; pause_n = 1'b0;
    exp_next("R4", v(1,0,0,1,0,0,0)); tick(1);
    sel_n = 1'b1;
    exp_next("R4", v(0,0,0,1,0,0,1)); tick(1);
    exp_next("R4", v(0,0,0,1,0,0,0)); tick(1);
    // R2: pause line ignored while deselected
    exp_next("R2", v(0,0,0,1,0,0,0)); tick(1);
    pause_n = 1'b1; tick(1);

    // R6: sclk rising edge cancels the armed doze
    sel_n = 1'b0; tick(1);
    doze_cmd = 1'b1; tick(1);
    doze_cmd = 1'b0; sclk = 1'b1; tick(1);
    sclk = 1'b0; tick(1);
    sel_n = 1'b1;
    exp_next("R6", v(0,0,0,1,0,0,0)); tick(1);
    exp_next("R6", v(0,0,0,1,0,0,0)); tick(1);

    // R5/R6: sclk high at strobe, falling edge does not cancel
    sclk = 1'b1; tick(1);
    sel_n = 1'b0; tick(1);
    doze_cmd = 1'b1;
    exp_next("R5", v(0,0,0,1,0,0,0)); tick(1);
    doze_cmd = 1'b0; sclk = 1'b0; tick(1);
    sel_n = 1'b1;
    exp_next("R5", v(1,1,1,0,0,0,0)); tick(1);

    // R7: sclk toggling while dozing changes nothing
    sclk = 1'b1;
    exp_next("R7", v(1,1,1,0,0,0,0)); tick(1);
    sclk = 1'b0;
    exp_next("R7", v(1,1,1,0,0,0,0)); tick(1);

    // R8: wake countdown with select returning high
    c0 = cyc;
    sel_n = 1'b0;
    exp_next("R8", v(1,1,1,0,0,0,0)); tick(1);
    sel_n = 1'b1;
    exp_next("R8", v(1,1,1,0,0,0,0));
    exp_at(c0 + REC, "R8", v(1,1,1,0,0,0,0));
    exp_at(c0 + 1 + REC, "R8", v(0,0,0,1,0,1,0));
    exp_at(c0 + 2 + REC, "R8", v(0,0,0,1,0,0,0));
    tick(REC + 3);

    // R9: illegal second select fall during countdown
    sel_n = 1'b0; tick(1);
    doze_cmd = 1'b1; tick(1);
    doze_cmd = 1'b0; sel_n = 1'b1; tick(2);
    c0 = cyc;
    sel_n = 1'b0; tick(1);
    sel_n = 1'b1; tick(3);
    sel_n = 1'b0;
    exp_at(c0 + 5, "R9", v(1,1,1,0,1,0,0)); tick(1);
    sel_n = 1'b1;
    exp_at(c0 + REC, "R9", v(1,1,1,0,1,0,0));
    exp_at(c0 + 1 + REC, "R9", v(0,0,0,1,1,1,0));
    exp_at(c0 + 2 + REC, "R9", v(0,0,0,1,1,0,0));
    exp_at(c0 + 6 + REC, "R9", v(0,0,0,1,1,0,0));
    tick(REC + 8);

    while (q.size() > 0) tick(1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule